// File: doc/BRIEF.md
# Interrupt Mapping and Dispatch Controller

The controller gathers 64 level-sensitive interrupt lines into one outstanding request toward a processor. Lines 0 to 31 come from expansion slots and share one mapping register per group of four lines. Lines 32 to 63 come from on-board devices, and each has a mapping register of its own. Every mapping register carries an enable flag in its top bit. The lower 31 bits hold a fixed identification pattern that software can read but not change.

At most one interrupt number is pending at a time. While a number is pending, its request output stays high and no other number can take its place. Software ends a request with a write to a clear register, or with a write that disables the mapping register of the pending number. Every mapping write and every clear write starts a rescan. A rescan keeps a pending request that was not cleared. Otherwise it issues the lowest-numbered line that is high and enabled, so slot lines always win over on-board lines.

Software reaches the block through a simple register port. A write is a one-cycle strobe. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, nothing is pending, every request output is low and every enable flag is 0. Slot mapping register k reads 0x7C0 | (k<<2), and on-board mapping register j reads 0x7E0 + j.
- R2: A mapping-register write stores only write-data bit 31, the enable flag. Bits 30:0 always read back the fixed pattern from R1. Slot register k is at 0x0C04 + 8k and on-board register j is at 0x1004 + 8j.
- R3: When nothing is pending, a line that rises while its register is enabled becomes the pending number at the next clock edge. The pending number appears on pend_num_o, and only request output number n is high. When several enabled lines rise together, the lowest number wins.
- R4: While a request is pending, new rising lines do not change it, and at most one request output is high.
- R5: A line whose mapping register is disabled never raises a request.
- R6: A rescan keeps an uncleared pending request. Otherwise it picks the lowest-numbered high and enabled line, so any slot line goes before any on-board line.
- R7: A write to 0x1404 + 32g (g = 0..7, address bit 2 set) clears the pending request only if the pending number divided by 4 equals g. It then rescans.
- R8: A write to 0x1804 + 8j (up to offset 0x1860, address bit 2 set) clears the pending request only if the pending number equals 32 + j. It then rescans.
- R9: A mapping write with bit 31 = 0 clears the pending request when that register controls the pending number, then rescans.
- R10: A line that falls does not withdraw a request already issued for it.
- R11: Writes whose address bit 2 is clear are ignored. Reads of such words, and reads of unmapped offsets, return 0.
- R12: After a clear, a line that is still high and enabled is issued again by the rescan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl_i | input | 64 | Level interrupt lines; bits 0-31 slots, 32-63 on-board |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_rd_i | input | 1 | One-cycle read strobe |
| bus_addr_i | input | 16 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| req_o | output | 64 | One request line per interrupt number |
| pend_valid_o | output | 1 | A request is outstanding |
| pend_num_o | output | 6 | Outstanding interrupt number |

## Verification
The bench goes after the cases that set this block apart from a plain priority encoder.

- A group clear aimed at the wrong group, or an on-board clear for a different number, must leave the request in place. A design that decodes the clear index loosely would drop the request.
- A line that falls while its request is pending must keep the request. A design that tracks the line level would lose the interrupt.
- Clearing a request while its line is still high must issue the same number again.
- The rescan must prefer a low slot line over an on-board line. It must also fall through to the on-board lines when no slot line qualifies. A reversed search order would pick the wrong number.
- A lower-word write must change nothing, and reads must return the fixed identification bits with the stored enable flag.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned LOW_W = REG_W - 1;

  // fixed low bits of a slot mapping register
  function automatic logic [LOW_W-1:0] slot_map_low(input int unsigned idx);
    return LOW_W'(32'h7C0) | (LOW_W'(idx) << 2);
  endfunction

  // fixed low bits of an on-board mapping register
  function automatic logic [LOW_W-1:0] ob_map_low(input int unsigned idx);
    return LOW_W'(32'h7E0) + LOW_W'(idx);
  endfunction

  // group that a slot interrupt number belongs to
  function automatic int unsigned group_of(input int unsigned num, input int unsigned grp);
    return num / grp;
  endfunction
endpackage

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = 6
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) begin
        found_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/irqd_regs.sv
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned GRP   = 4,
  parameter int unsigned OBS   = 32,
  parameter int unsigned AW    = 16,
  parameter logic [AW-1:0] SLOT_MAP_BASE = 16'h0C00,
  parameter logic [AW-1:0] OB_MAP_BASE   = 16'h1000,
  parameter logic [AW-1:0] SLOT_CLR_BASE = 16'h1400,
  parameter logic [AW-1:0] OB_CLR_BASE   = 16'h1800,
  parameter logic [AW-1:0] OB_CLR_LAST   = 16'h1860,
  localparam int unsigned NGRP = SLOTS / GRP,
  localparam int unsigned GW   = $clog2(NGRP),
  localparam int unsigned OW   = $clog2(OBS),
  localparam int unsigned NIN  = SLOTS + OBS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wbit_i,
  output logic             map_slot_wr_o,
  output logic [GW-1:0]    map_slot_idx_o,
  output logic             map_ob_wr_o,
  output logic [OW-1:0]    map_ob_idx_o,
  output logic             clr_slot_wr_o,
  output logic [GW-1:0]    clr_slot_idx_o,
  output logic             clr_ob_wr_o,
  output logic [OW-1:0]    clr_ob_idx_o,
  output logic [NIN-1:0]   en_line_q_o,
  output logic [NIN-1:0]   en_line_next_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [AW-1:0] SM_SPAN = AW'(8 * NGRP);
  localparam logic [AW-1:0] OM_SPAN = AW'(8 * OBS);
  localparam logic [AW-1:0] SC_SPAN = AW'(32 * NGRP);
  localparam logic [AW-1:0] OC_TOP  = OB_CLR_LAST - OB_CLR_BASE;

  logic [AW-1:0] off_sm, off_om, off_sc, off_oc;
  logic          in_sm, in_om, in_sc, in_oc, hi_word;
  logic [GW-1:0] sm_idx, sc_idx;
  logic [OW-1:0] om_idx, oc_idx;

  assign off_sm  = addr_i - SLOT_MAP_BASE;
  assign off_om  = addr_i - OB_MAP_BASE;
  assign off_sc  = addr_i - SLOT_CLR_BASE;
  assign off_oc  = addr_i - OB_CLR_BASE;
  assign in_sm   = (addr_i >= SLOT_MAP_BASE) && (off_sm < SM_SPAN);
  assign in_om   = (addr_i >= OB_MAP_BASE)   && (off_om < OM_SPAN);
  assign in_sc   = (addr_i >= SLOT_CLR_BASE) && (off_sc < SC_SPAN);
  assign in_oc   = (addr_i >= OB_CLR_BASE)   && (off_oc <= OC_TOP);
  assign hi_word = addr_i[2];
  assign sm_idx  = off_sm[GW+2:3];
  assign om_idx  = off_om[OW+2:3];
  assign sc_idx  = off_sc[GW+4:5];
  assign oc_idx  = off_oc[OW+2:3];

  assign map_slot_wr_o  = wr_i && in_sm && hi_word;
  assign map_ob_wr_o    = wr_i && in_om && hi_word;
  assign clr_slot_wr_o  = wr_i && in_sc && hi_word;
  assign clr_ob_wr_o    = wr_i && in_oc && hi_word;
  assign map_slot_idx_o = sm_idx;
  assign map_ob_idx_o   = om_idx;
  assign clr_slot_idx_o = sc_idx;
  assign clr_ob_idx_o   = oc_idx;

  logic [NGRP-1:0] slot_en_q;
  logic [OBS-1:0]  ob_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_en_q <= '0;
      ob_en_q   <= '0;
    end else begin
      if (map_slot_wr_o) slot_en_q[sm_idx] <= wbit_i;
      if (map_ob_wr_o)   ob_en_q[om_idx]   <= wbit_i;
    end
  end

  // per-line enable, both current and with this cycle's write applied
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot_en
    assign en_line_q_o[k]    = slot_en_q[k / GRP];
    assign en_line_next_o[k] = (map_slot_wr_o && (sm_idx == GW'(k / GRP)))
                               ? wbit_i : slot_en_q[k / GRP];
  end
  for (genvar j = 0; j < OBS; j++) begin : g_ob_en
    assign en_line_q_o[SLOTS+j]    = ob_en_q[j];
    assign en_line_next_o[SLOTS+j] = (map_ob_wr_o && (om_idx == OW'(j)))
                                     ? wbit_i : ob_en_q[j];
  end

  logic [REG_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (hi_word && in_sm)      rd_val = {slot_en_q[sm_idx], slot_map_low(32'(sm_idx))};
    else if (hi_word && in_om) rd_val = {ob_en_q[om_idx], ob_map_low(32'(om_idx))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/irqd_pend.sv
module irqd_pend #(
  parameter int unsigned NIN = 64,
  localparam int unsigned NW = $clog2(NIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_i,
  input  logic          clr_hit_i,
  input  logic          cand_found_i,
  input  logic [NW-1:0] cand_idx_i,
  output logic          issue_o,
  output logic          pend_vld_o,
  output logic [NW-1:0] pend_num_o
);
  logic          nxt_vld;
  logic [NW-1:0] nxt_num;

  always_comb begin
    nxt_vld = pend_vld_o;
    nxt_num = pend_num_o;
    issue_o = 1'b0;
    if (scan_i) begin
      if (clr_hit_i || !pend_vld_o) begin
        nxt_vld = cand_found_i;
        nxt_num = cand_found_i ? cand_idx_i : '0;
        issue_o = cand_found_i;
      end
    end else if (!pend_vld_o && cand_found_i) begin
      nxt_vld = 1'b1;
      nxt_num = cand_idx_i;
      issue_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_o <= 1'b0;
      pend_num_o <= '0;
    end else begin
      pend_vld_o <= nxt_vld;
      pend_num_o <= nxt_num;
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned GRP   = 4,
  parameter int unsigned OBS   = 32,
  parameter int unsigned AW    = 16,
  localparam int unsigned NIN  = SLOTS + OBS,
  localparam int unsigned NW   = $clog2(NIN),
  localparam int unsigned NGRP = SLOTS / GRP,
  localparam int unsigned GW   = $clog2(NGRP),
  localparam int unsigned OW   = $clog2(OBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIN-1:0]   irq_lvl_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  output logic [NIN-1:0]   req_o,
  output logic             pend_valid_o,
  output logic [NW-1:0]    pend_num_o
);
  logic          map_slot_wr, map_ob_wr, clr_slot_wr, clr_ob_wr;
  logic [GW-1:0] map_slot_idx, clr_slot_idx;
  logic [OW-1:0] map_ob_idx, clr_ob_idx;
  logic [NIN-1:0] en_q, en_next;
  logic          wbit;
  logic          unused_wdata;

  assign wbit         = bus_wdata_i[REG_W-1];
  assign unused_wdata = ^bus_wdata_i[REG_W-2:0];

  irqd_regs #(.SLOTS(SLOTS), .GRP(GRP), .OBS(OBS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .addr_i(bus_addr_i), .wbit_i(wbit),
    .map_slot_wr_o(map_slot_wr), .map_slot_idx_o(map_slot_idx),
    .map_ob_wr_o(map_ob_wr), .map_ob_idx_o(map_ob_idx),
    .clr_slot_wr_o(clr_slot_wr), .clr_slot_idx_o(clr_slot_idx),
    .clr_ob_wr_o(clr_ob_wr), .clr_ob_idx_o(clr_ob_idx),
    .en_line_q_o(en_q), .en_line_next_o(en_next),
    .rdata_o(bus_rdata_o)
  );

  // line history for edge detection
  logic [NIN-1:0] lvl_q, rise, rise_en;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= irq_lvl_i;
  end
  assign rise    = irq_lvl_i & ~lvl_q;
  assign rise_en = rise & en_q;

  // clear conditions against the pending number
  int unsigned pend_int;
  logic hit_map_slot, hit_map_ob, hit_clr_slot, hit_clr_ob, clr_hit, scan;
  assign pend_int     = 32'(pend_num_o);
  assign hit_map_slot = map_slot_wr && !wbit && pend_valid_o && (pend_int < SLOTS)
                        && (group_of(pend_int, GRP) == 32'(map_slot_idx));
  assign hit_map_ob   = map_ob_wr && !wbit && pend_valid_o
                        && (pend_int == SLOTS + 32'(map_ob_idx));
  assign hit_clr_slot = clr_slot_wr && pend_valid_o
                        && (group_of(pend_int, GRP) == 32'(clr_slot_idx));
  assign hit_clr_ob   = clr_ob_wr && pend_valid_o
                        && (pend_int == SLOTS + 32'(clr_ob_idx));
  assign clr_hit      = hit_map_slot | hit_map_ob | hit_clr_slot | hit_clr_ob;
  assign scan         = map_slot_wr | map_ob_wr | clr_slot_wr | clr_ob_wr;

  // one picker serves both rescan and edge issue
  logic [NIN-1:0] cand_vec;
  logic           cand_found;
  logic [NW-1:0]  cand_idx;
  logic           issue_evt;
  assign cand_vec = scan ? (irq_lvl_i & en_next) : rise_en;

  irqd_pick #(.W(NIN), .IW(NW)) u_pick (
    .vec_i(cand_vec), .found_o(cand_found), .idx_o(cand_idx)
  );

  irqd_pend #(.NIN(NIN)) u_pend (
    .clk(clk), .rst_n(rst_n), .scan_i(scan), .clr_hit_i(clr_hit),
    .cand_found_i(cand_found), .cand_idx_i(cand_idx),
    .issue_o(issue_evt), .pend_vld_o(pend_valid_o), .pend_num_o(pend_num_o)
  );

  for (genvar n = 0; n < NIN; n++) begin : g_req
    assign req_o[n] = pend_valid_o && (pend_num_o == NW'(n));
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned NIN   = 64,
  parameter int unsigned NW    = 6,
  parameter int unsigned OW    = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr_i,
  input logic [NIN-1:0] req_o,
  input logic           pend_valid_o,
  input logic [NW-1:0]  pend_num_o,
  input logic [NIN-1:0] rise_en,
  input logic           clr_ob_wr,
  input logic [OW-1:0]  clr_ob_idx
);
  logic [NW-1:0] ob_clr_num;
  assign ob_clr_num = NW'(SLOTS) + NW'(clr_ob_idx);

  p_single_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_o));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid_o |-> (req_o == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid_o && !bus_wr_i) |=> (pend_valid_o && pend_num_o == $past(pend_num_o)));

  p_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_valid_o && !bus_wr_i && (|rise_en)) |=> pend_valid_o);

  p_ob_clr_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ob_wr && pend_valid_o && pend_num_o != ob_clr_num)
    |=> (pend_valid_o && pend_num_o == $past(pend_num_o)));
endmodule

bind irq_dispatch irq_dispatch_chk #(.SLOTS(SLOTS), .NIN(NIN), .NW(NW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .req_o(req_o),
  .pend_valid_o(pend_valid_o), .pend_num_o(pend_num_o), .rise_en(rise_en),
  .clr_ob_wr(clr_ob_wr), .clr_ob_idx(clr_ob_idx)
);

// File: tb/tb_irq_dispatch.sv
`timescale 1ns/1ps
module tb_irq_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] lvl = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] req;
  logic        pvld;
  logic [5:0]  pnum;

  always #10 clk = ~clk;

  irq_dispatch dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl_i(lvl), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .req_o(req), .pend_valid_o(pvld), .pend_num_o(pnum)
  );

  typedef struct {
    bit          is_read;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (it.is_read) begin
          if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: rdata act=%h exp=%h", it.tag, rdata, it.exp);
          end
        end else begin
          logic        ev;
          logic [5:0]  en;
          logic [63:0] ereq;
          ev   = it.exp[8];
          en   = it.exp[5:0];
          ereq = ev ? (64'd1 << en) : 64'd0;
          if (pvld !== ev || req !== ereq || (ev && pnum !== en)) begin
            errors++;
            $display("FAIL %s: valid=%b num=%0d req=%h exp valid=%b num=%0d req=%h",
                     it.tag, pvld, pnum, req, ev, en, ereq);
          end
        end
      end
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); rd = 1'b1; addr = a;
    @(posedge clk); #1; rd = 1'b0;
    it.is_read = 1'b1; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic set_line(input int n, input logic v);
    @(negedge clk); lvl[n] = v;
    @(posedge clk); #1;
  endtask

  task automatic expect_pend(input logic v, input int n, input string tag);
    item_t it;
    it.is_read = 1'b0; it.exp = {23'd0, v, 2'd0, 6'(n)}; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    expect_pend(1'b0, 0, "R1 idle after reset");
    bus_read(16'h0C1C, 32'h0000_07CC, "R1 slot reg 3 reset");
    bus_read(16'h102C, 32'h0000_07E5, "R1 onboard reg 5 reset");

    bus_write(16'h0C0C, 32'h8000_1234);
    bus_read(16'h0C0C, 32'h8000_07C4, "R2 only enable stored");
    bus_write(16'h0C00, 32'h8000_0000);
    bus_read(16'h0C04, 32'h0000_07C0, "R11 lower word write ignored");
    bus_read(16'h2004, 32'h0, "R11 unmapped read zero");
    expect_pend(1'b0, 0, "R11 no request");

    set_line(6, 1'b1);
    expect_pend(1'b1, 6, "R3 rise issues");
    @(negedge clk); lvl[5] = 1'b1; lvl[40] = 1'b1; @(posedge clk); #1;
    expect_pend(1'b1, 6, "R4 pending kept");
    set_line(6, 1'b0);
    expect_pend(1'b1, 6, "R10 fall keeps request");

    bus_write(16'h1404, 32'h0);
    expect_pend(1'b1, 6, "R7 wrong group clear");
    bus_write(16'h1804, 32'h0);
    expect_pend(1'b1, 6, "R8 wrong onboard clear");
    bus_write(16'h1424, 32'h0);
    expect_pend(1'b1, 5, "R12 rescan reissues high line");

    bus_write(16'h1044, 32'h8000_0000);
    expect_pend(1'b1, 5, "R6 rescan keeps pending");
    set_line(5, 1'b0);
    bus_write(16'h1424, 32'h0);
    expect_pend(1'b1, 40, "R6 fall through to onboard");

    set_line(2, 1'b1);
    bus_write(16'h0C04, 32'h8000_0000);
    expect_pend(1'b1, 40, "R6 pending kept on enable");
    bus_write(16'h1844, 32'h0);
    expect_pend(1'b1, 2, "R8 clear then slot first");

    bus_write(16'h0C04, 32'h0);
    expect_pend(1'b1, 40, "R9 disable clears slot group");
    bus_write(16'h1044, 32'h0);
    expect_pend(1'b0, 0, "R9 disable clears onboard");
    @(posedge clk); #1;
    expect_pend(1'b0, 0, "R5 disabled lines silent");
    bus_read(16'h1044, 32'h0000_07E8, "R2 onboard readback");

    bus_write(16'h0C14, 32'h8000_0000);
    bus_write(16'h1054, 32'h8000_0000);
    @(negedge clk); lvl[9] = 1'b1; lvl[42] = 1'b1; @(posedge clk); #1;
    expect_pend(1'b1, 9, "R3 lowest of simultaneous");
    bus_write(16'h1444, 32'h0);
    expect_pend(1'b1, 9, "R12 same number again");
    set_line(9, 1'b0);
    bus_write(16'h1444, 32'h0);
    expect_pend(1'b1, 42, "R7 clear then onboard");
    bus_write(16'h1854, 32'h0);
    expect_pend(1'b1, 42, "R8 exact clear reissue");
    set_line(42, 1'b0);
    bus_write(16'h1854, 32'h0);
    expect_pend(1'b0, 0, "R8 exact clear to idle");

    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule